// File: doc/BRIEF.md
# Processor Clock Power-State Controller

This block is a synchronous state machine that follows and sequences the clock power states of a processor core. It gets already-synchronized requests: a halt pulse, a stop-clock request, a sleep request, a bus-clock-stopped flag, snoop request and snoop-done signals, and a wake interrupt. From these it moves between seven states. A strap input is captured while reset is held. The strap fixes which of two mutually exclusive low-power states a stop-clock request leads to: a shallow grant state for multi-core platforms, or a lower-power quick state for single-core platforms.

The outputs are the current state (binary code and one-hot), a core clock gate enable, a one-cycle stop acknowledge, and a ready flag. The ready flag is low while the core is in its deepest state. Leaving that state takes a fixed wake-up latency, given as a cycle count. At 100 MHz the default count of 3000 equals 30 us. Every output is registered and changes on the same clock edge as the state code. All outputs reflect the inputs sampled at the previous rising edge.

Top module: `clk_pstate_ctrl`

## Requirements
- R1: There are exactly seven states, coded on `state_o` as Run=0, Grant=1, Halt=2, Quick=3, Snoop=4, Doze=5, Deep=6. Bit k of `state_oh_o` is high only when the code is k. While `rst` is high the state goes to Run.
- R2: `strap_i` is captured only while `rst` is high. It is then held until the next reset. From Run with `stop_req_i` high, a captured 0 leads to Quick and a captured 1 leads to Grant. Changes on `strap_i` after reset have no effect.
- R3: After a reset with strap 1, Quick (code 3) never appears. After a reset with strap 0, Grant (code 1) never appears.
- R4: In Run, a `halt_i` pulse with `stop_req_i` low leads to Halt. When both are high, `stop_req_i` wins. In Halt, `wake_i` returns the state to Run.
- R5: In Grant or Quick, `stop_req_i` low returns the state to Run. This takes priority over every other input.
- R6: `snoop_req_i` in Halt, Grant or Quick leads to Snoop. In Snoop, `snoop_done_i` returns the state to the one it came from. In Halt, `wake_i` has priority over a snoop. In Grant, a snoop has priority over a sleep request.
- R7: Doze is entered only from Grant, when `sleep_i` is high. In Doze, `bus_clk_off_i` high leads to Deep. Otherwise, `sleep_i` low leads back to Grant.
- R8: Deep is entered only from Doze. At the first edge in Deep that samples `bus_clk_off_i` low, the wake count starts. The state returns to Doze at the WAKE_CYCLES-th edge, counting that first edge as the first. Raising `bus_clk_off_i` again during the count has no effect.
- R9: `ready_o` is low exactly while the state is Deep.
- R10: `core_clk_en_o` is high exactly in Run and Snoop.
- R11: `stop_ack_o` is high for one cycle, in the first cycle that the state shows Grant or Quick after any other state.
- R12: Any input that matches no listed transition leaves the state unchanged. Examples: `halt_i` outside Run, `sleep_i` in Quick, `snoop_done_i` outside Snoop, `snoop_req_i` in Run or Doze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 1 | Low-power target strap, captured during reset |
| halt_i | input | 1 | One-cycle halt instruction pulse |
| stop_req_i | input | 1 | Stop-clock request, level |
| sleep_i | input | 1 | Sleep request, level |
| bus_clk_off_i | input | 1 | Bus clock is stopped |
| snoop_req_i | input | 1 | Snoop request |
| snoop_done_i | input | 1 | Snoop finished |
| wake_i | input | 1 | Wake interrupt |
| state_o | output | 3 | Current state code |
| state_oh_o | output | 7 | Current state, one-hot |
| core_clk_en_o | output | 1 | Core clock gate enable |
| stop_ack_o | output | 1 | Stop acknowledge pulse |
| ready_o | output | 1 | Core ready, low during Deep |

## Verification
The bench builds the block with WAKE_CYCLES = 5. This lets each Deep exit, including a count that is disturbed by the bus clock stopping again, complete within a handful of cycles. A long constrained-random phase then makes many complete Doze to Deep to Doze round trips. The short count also lets the bench check the exact exit edge, not only that the exit eventually happens. Directed phases reset the block under both strap values, so that both mutually exclusive low-power states and their exclusion are exercised.

// File: rtl/clk_pstate_pkg.sv
package clk_pstate_pkg;
  localparam int NSTATES = 7;
  localparam int SW      = 3;

  typedef enum logic [SW-1:0] {
    PS_RUN   = 3'd0,
    PS_GRANT = 3'd1,
    PS_HALT  = 3'd2,
    PS_QUICK = 3'd3,
    PS_SNOOP = 3'd4,
    PS_DOZE  = 3'd5,
    PS_DEEP  = 3'd6
  } pstate_e;
endpackage

// File: rtl/pstate_strap_latch.sv
module pstate_strap_latch (
  input  logic clk,
  input  logic rst,
  input  logic strap_i,
  output logic grant_mode_o
);
  always_ff @(posedge clk) begin
    if (rst) grant_mode_o <= strap_i;
  end
endmodule

// File: rtl/pstate_wake_timer.sv
module pstate_wake_timer #(
  parameter int WAKE_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic in_deep_i,
  input  logic bus_clk_off_i,
  output logic expire_o
);
  localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic          counting;

  assign counting = in_deep_i && (active_q || !bus_clk_off_i);
  assign expire_o = counting && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !in_deep_i) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (counting) begin
      if (expire_o) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
        active_q <= 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R8
  AST_IDLE_OUTSIDE_DEEP: assert property (@(posedge clk) disable iff (rst)
    !in_deep_i |=> (cnt_q == '0) && !active_q); // R8
endmodule

// File: rtl/pstate_next.sv
module pstate_next
  import clk_pstate_pkg::*;
(
  input  pstate_e cur_i,
  input  pstate_e ret_i,
  input  logic    grant_mode_i,
  input  logic    halt_i,
  input  logic    stop_req_i,
  input  logic    sleep_i,
  input  logic    bus_clk_off_i,
  input  logic    snoop_req_i,
  input  logic    snoop_done_i,
  input  logic    wake_i,
  input  logic    wake_expire_i,
  output pstate_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    unique case (cur_i)
      PS_RUN: begin
        if (stop_req_i)  nxt_o = grant_mode_i ? PS_GRANT : PS_QUICK;
        else if (halt_i) nxt_o = PS_HALT;
      end
      PS_HALT: begin
        if (wake_i)           nxt_o = PS_RUN;
        else if (snoop_req_i) nxt_o = PS_SNOOP;
      end
      PS_GRANT: begin
        if (!stop_req_i)      nxt_o = PS_RUN;
        else if (snoop_req_i) nxt_o = PS_SNOOP;
        else if (sleep_i)     nxt_o = PS_DOZE;
      end
      PS_QUICK: begin
        if (!stop_req_i)      nxt_o = PS_RUN;
        else if (snoop_req_i) nxt_o = PS_SNOOP;
      end
      PS_SNOOP: begin
        if (snoop_done_i) nxt_o = ret_i;
      end
      PS_DOZE: begin
        if (bus_clk_off_i) nxt_o = PS_DEEP;
        else if (!sleep_i) nxt_o = PS_GRANT;
      end
      PS_DEEP: begin
        if (wake_expire_i) nxt_o = PS_DOZE;
      end
      default: nxt_o = PS_RUN;
    endcase
  end
endmodule

// File: rtl/pstate_outreg.sv
module pstate_outreg
  import clk_pstate_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  pstate_e             nxt_i,
  output pstate_e             state_o,
  output logic [NSTATES-1:0]  state_oh_o,
  output logic                core_clk_en_o,
  output logic                stop_ack_o,
  output logic                ready_o
);
  logic [NSTATES-1:0] oh_d;
  logic               stopped_d;

  for (genvar k = 0; k < NSTATES; k++) begin : g_oh
    assign oh_d[k] = (nxt_i == pstate_e'(k));
  end

  assign stopped_d = (nxt_i == PS_GRANT) || (nxt_i == PS_QUICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o       <= PS_RUN;
      state_oh_o    <= NSTATES'(1);
      core_clk_en_o <= 1'b1;
      stop_ack_o    <= 1'b0;
      ready_o       <= 1'b1;
    end else begin
      state_o       <= nxt_i;
      state_oh_o    <= oh_d;
      core_clk_en_o <= (nxt_i == PS_RUN) || (nxt_i == PS_SNOOP);
      stop_ack_o    <= stopped_d && (nxt_i != state_o);
      ready_o       <= (nxt_i != PS_DEEP);
    end
  end
endmodule

// File: rtl/clk_pstate_ctrl.sv
module clk_pstate_ctrl
  import clk_pstate_pkg::*;
#(
  parameter int WAKE_CYCLES = 3000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strap_i,
  input  logic               halt_i,
  input  logic               stop_req_i,
  input  logic               sleep_i,
  input  logic               bus_clk_off_i,
  input  logic               snoop_req_i,
  input  logic               snoop_done_i,
  input  logic               wake_i,
  output logic [SW-1:0]      state_o,
  output logic [NSTATES-1:0] state_oh_o,
  output logic               core_clk_en_o,
  output logic               stop_ack_o,
  output logic               ready_o
);
  pstate_e cur;
  pstate_e nxt;
  pstate_e ret_q;
  logic    grant_mode;
  logic    wake_expire;

  pstate_strap_latch u_strap (
    .clk(clk), .rst(rst), .strap_i(strap_i), .grant_mode_o(grant_mode)
  );

  pstate_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .in_deep_i(cur == PS_DEEP),
    .bus_clk_off_i(bus_clk_off_i), .expire_o(wake_expire)
  );

  pstate_next u_next (
    .cur_i(cur), .ret_i(ret_q), .grant_mode_i(grant_mode),
    .halt_i(halt_i), .stop_req_i(stop_req_i), .sleep_i(sleep_i),
    .bus_clk_off_i(bus_clk_off_i), .snoop_req_i(snoop_req_i),
    .snoop_done_i(snoop_done_i), .wake_i(wake_i),
    .wake_expire_i(wake_expire), .nxt_o(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) ret_q <= PS_HALT;
    else if (nxt == PS_SNOOP && cur != PS_SNOOP) ret_q <= cur;
  end

  pstate_outreg u_out (
    .clk(clk), .rst(rst), .nxt_i(nxt), .state_o(cur),
    .state_oh_o(state_oh_o), .core_clk_en_o(core_clk_en_o),
    .stop_ack_o(stop_ack_o), .ready_o(ready_o)
  );

  assign state_o = cur;

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
    $countones(state_oh_o) == 1 && state_oh_o[cur]); // R1
  AST_STRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
    grant_mode ? (cur != PS_QUICK) : (cur != PS_GRANT)); // R3
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (cur == PS_RUN && halt_i && !stop_req_i) |=> (cur == PS_HALT)); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ((cur == PS_GRANT || cur == PS_QUICK) && !stop_req_i) |=> (cur == PS_RUN)); // R5
  AST_SNOOP_RETURN: assert property (@(posedge clk) disable iff (rst)
    (cur == PS_SNOOP && snoop_done_i) |=> (cur == ret_q)); // R6
  AST_DEEP_FROM_DOZE: assert property (@(posedge clk) disable iff (rst)
    (cur == PS_DEEP && $past(cur) != PS_DEEP) |-> ($past(cur) == PS_DOZE)); // R8
  AST_READY_DEEP: assert property (@(posedge clk) disable iff (rst)
    ready_o == (cur != PS_DEEP)); // R9
  AST_CLK_GATE: assert property (@(posedge clk) disable iff (rst)
    core_clk_en_o == (cur == PS_RUN || cur == PS_SNOOP)); // R10
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    stop_ack_o |-> ((cur == PS_GRANT || cur == PS_QUICK) && $past(cur) != cur)); // R11
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stop_ack_o |=> !stop_ack_o); // R11
  AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cur == PS_RUN && !stop_req_i && !halt_i) |=> (cur == PS_RUN)); // R12
endmodule

// File: tb/sim_clk_pstate_ctrl.sv
module sim_clk_pstate_ctrl;
  localparam int W = 5;

  logic clk = 0;
  logic rst, strap, halt, stopr, sleepr, bcoff, snq, snd, wake;
  logic [2:0] st;
  logic [6:0] oh;
  logic cken, ack, rdy;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";
  bit armed = 0;

  // reference model state
  int m_st = 0, m_ret = 2, m_wait = 0;
  bit m_strap = 0, m_act = 0, m_ack = 0;

  always #5 clk = ~clk;

  clk_pstate_ctrl #(.WAKE_CYCLES(W)) u0 (
    .clk(clk), .rst(rst), .strap_i(strap), .halt_i(halt), .stop_req_i(stopr),
    .sleep_i(sleepr), .bus_clk_off_i(bcoff), .snoop_req_i(snq),
    .snoop_done_i(snd), .wake_i(wake), .state_o(st), .state_oh_o(oh),
    .core_clk_en_o(cken), .stop_ack_o(ack), .ready_o(rdy)
  );

  always @(posedge clk) begin
    int prev;
    prev = m_st;
    if (rst) begin
      m_st = 0; m_strap = strap; m_wait = 0; m_act = 0; m_ret = 2;
    end else begin
      case (m_st)
        0: if (stopr) m_st = m_strap ? 1 : 3; else if (halt) m_st = 2;
        2: if (wake) m_st = 0; else if (snq) begin m_ret = 2; m_st = 4; end
        1: if (!stopr) m_st = 0; else if (snq) begin m_ret = 1; m_st = 4; end
           else if (sleepr) m_st = 5;
        3: if (!stopr) m_st = 0; else if (snq) begin m_ret = 3; m_st = 4; end
        4: if (snd) m_st = m_ret;
        5: if (bcoff) m_st = 6; else if (!sleepr) m_st = 1;
        6: if (m_act || !bcoff) begin
             m_act = 1; m_wait++;
             if (m_wait == W) begin m_st = 5; m_wait = 0; m_act = 0; end
           end
        default: m_st = 0;
      endcase
    end
    m_ack = !rst && (m_st == 1 || m_st == 3) && (prev != m_st);
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", t, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (armed) begin
      chk({tag, " state"}, int'(st), m_st);
      chk("R1 onehot", int'(oh), 1 << m_st);
      chk("R9 ready", int'(rdy), (m_st != 6) ? 1 : 0);
      chk("R10 clk_en", int'(cken), (m_st == 0 || m_st == 4) ? 1 : 0);
      chk("R11 ack", int'(ack), int'(m_ack));
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr;
    halt = 0; snq = 0; snd = 0; wake = 0;
  endtask

  task automatic do_reset(input bit s);
    rst = 1; strap = s; stopr = 0; sleepr = 0; bcoff = 0; clr();
    step(3);
    rst = 0; armed = 1;
  endtask

  initial begin
    rst = 1; strap = 1; stopr = 0; sleepr = 0; bcoff = 0; clr();
    step(2);
    tag = "R1";
    do_reset(1);
    chk("R1 reset state", int'(st), 0);
    // halt path
    tag = "R4"; halt = 1; step(1); clr(); step(1);
    chk("R4 halt entry", int'(st), 2);
    tag = "R6"; snq = 1; step(1); clr(); step(2);
    snd = 1; step(1); clr(); step(1);
    chk("R6 snoop return to halt", int'(st), 2);
    tag = "R12"; snd = 1; halt = 1; step(2); clr();
    tag = "R4"; wake = 1; step(1); clr(); step(1);
    // grant path with halt collision
    tag = "R2"; stopr = 1; halt = 1; step(1); clr(); step(1);
    chk("R2 strap1 grant", int'(st), 1);
    tag = "R12"; halt = 1; wake = 1; step(2); clr();
    tag = "R6"; snq = 1; sleepr = 1; step(1); clr(); step(2);
    snd = 1; step(1); clr(); step(1);
    tag = "R7"; step(2);
    chk("R7 doze entry", int'(st), 5);
    bcoff = 1; step(4);
    tag = "R8"; bcoff = 0; step(2); bcoff = 1; step(1); bcoff = 0; step(W + 2);
    chk("R8 back in doze", int'(st), 5);
    tag = "R7"; sleepr = 0; step(2);
    tag = "R5"; stopr = 0; step(2);
    chk("R5 run again", int'(st), 0);
    // quick path
    do_reset(0);
    tag = "R2"; strap = 1; stopr = 1; step(2);
    chk("R2 strap0 quick", int'(st), 3);
    tag = "R12"; sleepr = 1; halt = 1; step(2); clr(); sleepr = 0;
    tag = "R6"; snq = 1; step(1); clr(); step(1); snd = 1; step(1); clr(); step(1);
    tag = "R5"; stopr = 0; step(2);
    tag = "R12"; snq = 1; snd = 1; step(2); clr();
    // random phase
    tag = "R3";
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 900) == 0) begin
        do_reset(1'($urandom));
        tag = "R3";
      end
      halt = (($urandom % 8) == 0);
      snq = (($urandom % 6) == 0);
      snd = (($urandom % 3) == 0);
      wake = (($urandom % 10) == 0);
      if (($urandom % 12) == 0) stopr = ~stopr;
      if (($urandom % 10) == 0) sleepr = ~sleepr;
      if (($urandom % 7) == 0) bcoff = ~bcoff;
      step(1);
    end
    clr();
    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule